// File: doc/BRIEF.md
# Fixed-Point Multiply-Add with Output Quantizer

This block evaluates y = a*b + c, one element at a time, on signed two's-complement fixed-point numbers. Each operand has its own width and fraction-bit count, given by parameters. The product is formed exactly, in a format whose width and fraction count are the sums of those of the two factors. The addend is then aligned to the product's binary point. Their sum is held in a format one carry bit wider than the larger integer part of the two, so no bits are lost before the output. A single quantize step then moves the sum into the declared target format. It drops low fraction bits toward negative infinity, and it either wraps or saturates on overflow.

Operand triples arrive on a valid/ready stream, one per beat, and results leave on a second valid/ready stream. A beat moves on an input or output when valid and ready are both high at a rising clock edge. While the consumer holds `out_ready` low, the presented result and `out_valid` stay frozen. The block buffers at most two beats. When both are occupied and the output is stalled, `in_ready` falls. Because `in_ready` is formed from `out_ready` in the same cycle, an unstalled stream runs at one beat per clock.

The overflow mode is sampled together with the operands and travels with the beat. Parameter sets whose derived product or sum width exceeds 64 bits are rejected at elaboration.

Top module: `fxp_mac_quant`

## Requirements
- R1: With the default formats (all operands and the result are 8 bits wide with 4 fraction bits), out_y is the exact value of a*b + c brought to the target format with only one rounding. The product format has 16 bits with 8 fraction bits, and the sum format has 17 bits with 8 fraction bits. For example, raw inputs (24, 32, 8) give raw 56, which is 3.5.
- R2: Dropped fraction bits truncate toward negative infinity. Raw 1*1 + 0 gives raw 0, and raw 1*(-1) + 0 gives raw -1.
- R3: When sat_en is 0 (wrap mode), an out-of-range result keeps only its low Y_WIDTH bits. Raw (127, 127, 127) gives 111, and raw (-128, 127, -128) gives -120.
- R4: When sat_en is 1 (saturate mode), an out-of-range result clamps to 127 (0x7F) or -128 (0x80). An in-range result is identical to the wrap-mode result.
- R5: With no stall, a triple accepted at a rising edge appears on out_y with out_valid high after the second rising edge that follows it (latency 2).
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_y does not change.
- R7: in_ready is low only when out_valid is high and out_ready is low. With the output stalled, exactly two triples are accepted before in_ready falls.
- R8: Whenever out_ready is high, in_ready is high, so a continuous stream is accepted every cycle.
- R9: During and right after reset, out_valid is 0 and in_ready is 1.
- R10: Results leave in acceptance order, each exactly once, under any pattern of in_valid and out_ready.
- R11: The overflow mode is captured with its triple. Changing sat_en after acceptance does not alter that triple's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sat_en | input | 1 | Overflow mode for the beat being offered: 0 wrap, 1 saturate |
| in_valid | input | 1 | Operand triple present |
| in_ready | output | 1 | Block can take a triple this cycle |
| in_a | input | A_WIDTH | Multiplicand, signed, A_FRAC fraction bits |
| in_b | input | B_WIDTH | Multiplier, signed, B_FRAC fraction bits |
| in_c | input | C_WIDTH | Addend, signed, C_FRAC fraction bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_y | output | Y_WIDTH | Quantized result, signed, Y_FRAC fraction bits |

## Verification
The assertions watch the stream contract on every cycle: held results under back-pressure, the rule that in_ready drops only when the output is full and stalled, full throughput while the consumer is ready, and the two-cycle latency when nothing stalls. The numeric behaviour can only be shown by the bench's scenarios. That covers the exact sum, floor truncation, wrap versus clamp, and the mode travelling with its beat. The bench also shows ordering under random back-pressure, comparing outputs against values it computes in wide integer arithmetic.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

  typedef enum logic {
    OVF_WRAP = 1'b0,
    OVF_SAT  = 1'b1
  } ovf_mode_e;

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/fxp_mul_align.sv
// Exact product and addend, both placed on the sum's binary point.
module fxp_mul_align #(
  parameter int A_W = 8,
  parameter int A_F = 4,
  parameter int B_W = 8,
  parameter int B_F = 4,
  parameter int C_W = 8,
  parameter int C_F = 4,
  parameter int S_W = 17,
  parameter int S_F = 8
) (
  input  logic [A_W-1:0]        a_i,
  input  logic [B_W-1:0]        b_i,
  input  logic [C_W-1:0]        c_i,
  output logic signed [S_W-1:0] prod_o,
  output logic signed [S_W-1:0] addend_o
);
  localparam int P_W = A_W + B_W;
  localparam int P_F = A_F + B_F;

  logic signed [P_W-1:0] prod_raw;

  assign prod_raw = P_W'($signed(a_i)) * P_W'($signed(b_i));
  assign prod_o   = S_W'(prod_raw) <<< (S_F - P_F);
  assign addend_o = S_W'($signed(c_i)) <<< (S_F - C_F);

endmodule

// File: rtl/fxp_quantize.sv
// The single lossy step: floor truncation, then wrap or clamp.
module fxp_quantize
  import fxp_mac_pkg::*;
#(
  parameter int SUM_W = 17,
  parameter int SUM_F = 8,
  parameter int Y_W   = 8,
  parameter int Y_F   = 4
) (
  input  logic signed [SUM_W-1:0] sum_i,
  input  ovf_mode_e               mode_i,
  output logic [Y_W-1:0]          y_o
);
  localparam int T_W = SUM_W - SUM_F + Y_F;
  localparam int X_W = imax(T_W, Y_W) + 1;
  localparam int H_W = X_W - Y_W + 1;
  localparam logic [Y_W-1:0] MAX_CODE = {1'b0, {(Y_W-1){1'b1}}};
  localparam logic [Y_W-1:0] MIN_CODE = {1'b1, {(Y_W-1){1'b0}}};

  logic signed [T_W-1:0] trunc_v;
  logic signed [X_W-1:0] ext_v;
  logic [H_W-1:0]        head;
  logic                  fits;

  generate
    if (SUM_F >= Y_F) begin : g_drop
      assign trunc_v = T_W'(sum_i >>> (SUM_F - Y_F));
    end else begin : g_pad
      assign trunc_v = T_W'(sum_i) <<< (Y_F - SUM_F);
    end
  endgenerate

  assign ext_v = X_W'(trunc_v);
  assign head  = ext_v[X_W-1:Y_W-1];
  assign fits  = (&head) | ~(|head);

  always_comb begin
    if (mode_i == OVF_SAT && !fits) begin
      y_o = ext_v[X_W-1] ? MIN_CODE : MAX_CODE;
    end else begin
      y_o = ext_v[Y_W-1:0];
    end
  end

endmodule

// File: rtl/fxp_mac_flow.sv
// Two-slot valid/ready control: operand stage and result stage.
module fxp_mac_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic out_ready,
  output logic out_valid,
  output logic s1_load,
  output logic s2_load
);
  logic s1_valid;
  logic out_free;

  assign out_free = !out_valid || out_ready;
  assign s2_load  = s1_valid && out_free;
  assign in_ready = !s1_valid || out_free;
  assign s1_load  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (s1_load) begin
        s1_valid <= 1'b1;
      end else if (s2_load) begin
        s1_valid <= 1'b0;
      end
      if (s2_load) begin
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fxp_mac_quant.sv
module fxp_mac_quant
  import fxp_mac_pkg::*;
#(
  parameter int A_WIDTH = 8,
  parameter int A_FRAC  = 4,
  parameter int B_WIDTH = 8,
  parameter int B_FRAC  = 4,
  parameter int C_WIDTH = 8,
  parameter int C_FRAC  = 4,
  parameter int Y_WIDTH = 8,
  parameter int Y_FRAC  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sat_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [A_WIDTH-1:0] in_a,
  input  logic [B_WIDTH-1:0] in_b,
  input  logic [C_WIDTH-1:0] in_c,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [Y_WIDTH-1:0] out_y
);
  // Derived full-precision formats.
  localparam int P_W   = A_WIDTH + B_WIDTH;
  localparam int P_F   = A_FRAC + B_FRAC;
  localparam int P_I   = P_W - P_F;
  localparam int C_I   = C_WIDTH - C_FRAC;
  localparam int SUM_F = imax(P_F, C_FRAC);
  localparam int SUM_I = imax(P_I, C_I) + 1;
  localparam int SUM_W = SUM_I + SUM_F;

  generate
    if (P_W > 64 || SUM_W > 64) begin : g_width_guard
      $error("fxp_mac_quant: derived intermediate width exceeds 64 bits");
    end
    if (A_FRAC > A_WIDTH || B_FRAC > B_WIDTH || C_FRAC > C_WIDTH || Y_FRAC > Y_WIDTH) begin : g_frac_guard
      $error("fxp_mac_quant: fraction count larger than width");
    end
  endgenerate

  logic s1_load;
  logic s2_load;

  logic signed [SUM_W-1:0] prod_c;
  logic signed [SUM_W-1:0] addend_c;
  logic signed [SUM_W-1:0] prod_q;
  logic signed [SUM_W-1:0] addend_q;
  ovf_mode_e               mode_q;
  logic signed [SUM_W-1:0] sum_c;
  logic [Y_WIDTH-1:0]      y_c;
  logic [Y_WIDTH-1:0]      y_q;

  fxp_mac_flow u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .s1_load   (s1_load),
    .s2_load   (s2_load)
  );

  fxp_mul_align #(
    .A_W (A_WIDTH), .A_F (A_FRAC),
    .B_W (B_WIDTH), .B_F (B_FRAC),
    .C_W (C_WIDTH), .C_F (C_FRAC),
    .S_W (SUM_W),   .S_F (SUM_F)
  ) u_align (
    .a_i      (in_a),
    .b_i      (in_b),
    .c_i      (in_c),
    .prod_o   (prod_c),
    .addend_o (addend_c)
  );

  // Stage 1: full-precision product, aligned addend, overflow mode.
  always_ff @(posedge clk) begin
    if (s1_load) begin
      prod_q   <= prod_c;
      addend_q <= addend_c;
      mode_q   <= ovf_mode_e'(sat_en);
    end
  end

  assign sum_c = prod_q + addend_q;

  fxp_quantize #(
    .SUM_W (SUM_W), .SUM_F (SUM_F),
    .Y_W   (Y_WIDTH), .Y_F (Y_FRAC)
  ) u_quant (
    .sum_i  (sum_c),
    .mode_i (mode_q),
    .y_o    (y_c)
  );

  // Stage 2: quantized result register.
  always_ff @(posedge clk) begin
    if (s2_load) begin
      y_q <= y_c;
    end
  end

  assign out_y = y_q;

endmodule

// File: rtl/fxp_mac_quant_chk.sv
module fxp_mac_quant_chk #(
  parameter int Y_W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [Y_W-1:0] out_y
);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y)));

  // R7
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R8
  stream_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  // R5
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready) ##1 out_ready |=> out_valid);

endmodule

bind fxp_mac_quant fxp_mac_quant_chk #(.Y_W(Y_WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_y     (out_y)
);

// File: tb/test_fxp_mac_quant.sv
module test_fxp_mac_quant;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sat_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic [7:0] in_c = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_y;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fxp_mac_quant i_fxp_mac_quant (
    .clk       (clk),
    .rst_n     (rst_n),
    .sat_en    (sat_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_c      (in_c),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_y     (out_y)
  );

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] c;
    logic       sat;
    logic [7:0] y;
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{8'd24,     8'd32,     8'd8,      1'b0, 8'd56,      8'd1}, // R1: 1.5*2+0.5
    '{8'(-32),   8'd24,     8'd4,      1'b0, 8'(-44),    8'd1}, // R1: -2*1.5+0.25
    '{8'd8,      8'(-16),   8'(-8),    1'b0, 8'(-16),    8'd1}, // R1: 0.5*-1-0.5
    '{8'(-16),   8'(-16),   8'(-16),   1'b0, 8'd0,       8'd1}, // R1: -1*-1-1
    '{8'd1,      8'd1,      8'd0,      1'b0, 8'd0,       8'd2}, // R2: floor of +tiny
    '{8'd1,      8'(-1),    8'd0,      1'b0, 8'(-1),     8'd2}, // R2: floor of -tiny
    '{8'd127,    8'd127,    8'd127,    1'b0, 8'd111,     8'd3}, // R3: wrap high
    '{8'(-128),  8'd127,    8'(-128),  1'b0, 8'(-120),   8'd3}, // R3: wrap low
    '{8'd127,    8'd127,    8'd127,    1'b1, 8'd127,     8'd4}, // R4: clamp high
    '{8'(-128),  8'd127,    8'(-128),  1'b1, 8'(-128),   8'd4}, // R4: clamp low
    '{8'd24,     8'd32,     8'd8,      1'b1, 8'd56,      8'd4}, // R4: in range untouched
    '{8'(-32),   8'd24,     8'd4,      1'b1, 8'(-44),    8'd4}  // R4: in range untouched
  };

  function automatic logic [7:0] ref_y(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic sat);
    longint p;
    longint s;
    longint t;
    p = longint'($signed(a)) * longint'($signed(b));
    s = p + (longint'($signed(c)) * 16);
    t = s >>> 4;
    if (sat && t > 127) return 8'd127;
    if (sat && t < -128) return 8'h80;
    return t[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Send one triple on an idle pipe, check latency and value.
  task automatic send_one(input vec_t v);
    @(negedge clk);
    in_a = v.a; in_b = v.b; in_c = v.c; sat_en = v.sat; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R5 early valid", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R5 valid at latency 2", int'(out_valid), 1);
    check(out_y == v.y, $sformatf("R%0d value", v.req),
          int'($signed(out_y)), int'($signed(v.y)));
  endtask

  logic [7:0] exp_q[$];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] next_rand(logic [31:0] x);
    logic [31:0] r;
    r = x ^ (x << 13);
    r = r ^ (r >> 17);
    r = r ^ (r << 5);
    return r;
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);

    // Table walk: R1..R5
    for (int i = 0; i < NVEC; i++) begin
      send_one(VECS[i]);
    end
    @(negedge clk);

    // Stall: R6, R7, R11
    out_ready = 1'b0;
    in_a = 8'd127; in_b = 8'd127; in_c = 8'd127; sat_en = 1'b1; in_valid = 1'b1; // X -> 127
    @(negedge clk);
    in_a = 8'h80; in_b = 8'd127; in_c = 8'h80; sat_en = 1'b1;                    // Y -> -128
    @(negedge clk);
    in_a = 8'd127; in_b = 8'd127; in_c = 8'd127; sat_en = 1'b0;                  // Z -> 111
    check(in_ready == 1'b0, "R7 in_ready low after two beats", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R7 in_ready stays low", int'(in_ready), 0);
    check(out_valid == 1'b1, "R6 out_valid held", int'(out_valid), 1);
    check(out_y == 8'd127, "R11 saturated beat kept its mode", int'($signed(out_y)), 127);
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R8 in_ready follows out_ready", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_y == 8'h80, "R11 second stalled beat", int'($signed(out_y)), -128);
    @(negedge clk);
    check(out_y == 8'd111, "R10 third beat in order", int'($signed(out_y)), 111);
    check(out_valid == 1'b1, "R10 third beat valid", int'(out_valid), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 pipe empty", int'(out_valid), 0);

    // Random stream with back-pressure: R10
    begin
      int sent = 0;
      int got = 0;
      for (int cyc = 0; cyc < 2000 && (sent < 60 || exp_q.size() != 0); cyc++) begin
        @(negedge clk);
        if (!in_valid && sent < 60) begin
          seed = next_rand(seed);
          in_a = seed[7:0]; in_b = seed[15:8]; in_c = seed[23:16]; sat_en = seed[24];
          in_valid = 1'b1;
        end
        seed = next_rand(seed);
        out_ready = seed[3] | seed[5];
        #1;
        if (out_valid && out_ready) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          got++;
          check(out_y == e, "R10 stream order/value", int'($signed(out_y)), int'($signed(e)));
        end
        if (in_valid && in_ready) begin
          exp_q.push_back(ref_y(in_a, in_b, in_c, sat_en));
          sent++;
          @(posedge clk);
          #1;
          in_valid = 1'b0;
        end
      end
      check(got == 60, "R10 all results delivered", got, 60);
    end

    out_ready = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule